// File: doc/BRIEF.md
# Serial-Loaded Output Enable Controller

This block sets which outputs of a ten-way clock fanout are live and which of two input clocks feeds them. A mode pin picks one of two behaviours. With the pin high (programmed mode), a word is clocked in one bit per configuration clock edge. The edge after the last bit commits the word to a control register. From then on the register drives the per-output enables and the input-select line.

Only one word is accepted. Once committed, the register holds until a configuration clock edge arrives with the mode pin low. That edge clears the sequence counter, the shift register and the control register. With the mode pin low (standard mode), every output is enabled and the serial data pin selects the input clock directly. A disabled output is reported as enable 0, which the output stage holds at logic low.

The asynchronous `rst_n` input brings the state to a known value at power-up. After that, only the mode pin clears the block. The `loaded` flag shows whether a word has been committed since the last clear.

Top module: `fanout_cfg_ctrl`

## Requirements
- R1: After `rst_n` is released with `prog_en` high and before any word is committed, `out_en` is all zeros, `clk_sel` is 0 and `loaded` is 0.
- R2: While `prog_en` is low, `out_en` is all ones and `clk_sel` follows `sdata` without waiting for a clock edge: 0 selects input clock 0 and 1 selects input clock 1.
- R3: During the first 11 rising edges of `clk` after a clear, with `prog_en` high, `out_en` and `clk_sel` stay at zero.
- R4: In the committed word, the bit sampled first drives `out_en[9]` and the next bit drives `out_en[8]`, continuing down to the tenth bit, which drives `out_en[0]`. The eleventh bit drives `clk_sel`. An enable value of 1 means the output is on and 0 means it is held low.
- R5: The 12th rising edge with `prog_en` high after a clear commits the word. The new `out_en` and `clk_sel` values are visible right after that edge.
- R6: After a commit, further rising edges with `prog_en` high do not change `out_en`, `clk_sel` or `loaded`, whatever `sdata` carries.
- R7: A rising edge of `clk` with `prog_en` low clears the counter, the shift register and the control register. This holds even when the edge arrives partway through a load. A full new load is accepted afterwards.
- R8: `loaded` rises on the commit edge and returns to 0 on the next rising edge with `prog_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock, rising-edge active |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| prog_en | input | 1 | Mode pin: 1 selects programmed mode, 0 selects standard mode and clears the block on a clock edge |
| sdata | input | 1 | Serial configuration data; selects the input clock directly in standard mode |
| out_en | output | 10 | Per-output enable, 1 = on, 0 = held low |
| clk_sel | output | 1 | Input clock select, 0 = clock 0, 1 = clock 1 |
| loaded | output | 1 | High once a word has been committed since the last clear |

## Verification
On every cycle, the assertions check these properties:
- a low-mode edge empties the state;
- the control register stays zero until a commit;
- the commit copies the shifted word exactly;
- a locked register stays stable;
- `loaded` rises only out of the commit count.

Some properties are visible only in the bench's scenarios:
- the serial bit order as seen at `out_en`;
- the exact edge on which the outputs change;
- the direct, combinational steering of `clk_sel` by `sdata` in standard mode;
- recovery after a load is abandoned partway through.

// File: rtl/fanout_cfg_ctrl.sv
module fanout_cfg_ctrl #(
  parameter int N_OUT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             sdata,
  output logic [N_OUT-1:0] out_en,
  output logic             clk_sel,
  output logic             loaded
);
  localparam int SR_W   = N_OUT + 1;
  localparam int COMMIT = SR_W;
  localparam int LOCK   = SR_W + 1;
  localparam int CNT_W  = $clog2(LOCK + 1);

  logic [SR_W-1:0]  shreg;
  logic [CNT_W-1:0] cnt;
  logic [N_OUT-1:0] ctrl_en;
  logic             ctrl_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      ctrl_en  <= '0;
      ctrl_sel <= 1'b0;
    end else if (!prog_en) begin
      shreg    <= '0;
      cnt      <= '0;
      ctrl_en  <= '0;
      ctrl_sel <= 1'b0;
    end else if (cnt < CNT_W'(COMMIT)) begin
      shreg <= {shreg[SR_W-2:0], sdata};
      cnt   <= cnt + 1'b1;
    end else if (cnt == CNT_W'(COMMIT)) begin
      ctrl_en  <= shreg[SR_W-1:1];
      ctrl_sel <= shreg[0];
      cnt      <= CNT_W'(LOCK);
    end
  end

  assign loaded  = (cnt == CNT_W'(LOCK));
  assign out_en  = prog_en ? ctrl_en : '1;
  assign clk_sel = prog_en ? ctrl_sel : sdata;

  AST_CLR_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> (cnt == '0 && shreg == '0 && ctrl_en == '0 && !ctrl_sel)); // R7

  AST_ZERO_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (ctrl_en == '0 && !ctrl_sel)); // R3

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && cnt == CNT_W'(COMMIT)) |=> (loaded && {ctrl_en, ctrl_sel} == $past(shreg))); // R5

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && loaded) |=> (loaded && $stable(ctrl_en) && $stable(ctrl_sel))); // R6

  AST_LOADED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> ($past(cnt) == CNT_W'(COMMIT) && $past(prog_en))); // R8

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(LOCK)); // R5
endmodule

// File: tb/test_fanout_cfg_ctrl.sv
module test_fanout_cfg_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_en = 1'b1;
  logic       sdata = 1'b0;
  logic [9:0] out_en;
  logic       clk_sel;
  logic       loaded;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  fanout_cfg_ctrl i_fanout_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sdata(sdata),
    .out_en(out_en), .clk_sel(clk_sel), .loaded(loaded)
  );

  localparam int NV = 6;
  localparam logic [10:0] VECS [NV] = '{11'h7FF, 11'h000, 11'h401, 11'h002, 11'h555, 11'h2AA};

  task automatic chk(input string req, input logic [9:0] e_en, input logic e_sel, input logic e_ld);
    n_chk++;
    if (out_en !== e_en || clk_sel !== e_sel || loaded !== e_ld) begin
      n_bad++;
      $display("FAIL %s: out_en=%b clk_sel=%b loaded=%b expected out_en=%b clk_sel=%b loaded=%b",
               req, out_en, clk_sel, loaded, e_en, e_sel, e_ld);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1ns;
  endtask

  task automatic clear_edge();
    prog_en = 1'b0;
    edge_step();
    prog_en = 1'b1;
    #1ns;
  endtask

  task automatic load_word(input logic [10:0] w, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      sdata = w[10-b];
      edge_step();
      chk("R3 shifting", 10'h000, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #5ns rst_n = 1'b1;
    edge_step();
    chk("R1 reset state", 10'h000, 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      clear_edge();
      load_word(VECS[v], 11);
      sdata = ~sdata;
      edge_step();
      chk("R4 R5 commit", VECS[v][10:1], VECS[v][0], 1'b1);
      for (int k = 0; k < 3; k++) begin
        sdata = k[0];
        edge_step();
        chk("R6 locked", VECS[v][10:1], VECS[v][0], 1'b1);
      end
    end

    prog_en = 1'b0; sdata = 1'b1; #1ns;
    chk("R2 standard sel1", 10'h3FF, 1'b1, 1'b1);
    sdata = 1'b0; #1ns;
    chk("R2 standard sel0", 10'h3FF, 1'b0, 1'b1);
    edge_step();
    chk("R8 loaded cleared", 10'h3FF, 1'b0, 1'b0);
    prog_en = 1'b1; #1ns;
    chk("R7 cleared ctrl", 10'h000, 1'b0, 1'b0);

    load_word(11'h7FF, 5);
    clear_edge();
    chk("R7 mid-load clear", 10'h000, 1'b0, 1'b0);
    load_word(11'h003, 11);
    edge_step();
    chk("R7 reload after clear", 10'h001, 1'b1, 1'b1);

    clear_edge();
    load_word(11'h7FF, 10);
    sdata = 1'b0;
    edge_step();
    chk("R5 no commit on 11th edge", 10'h000, 1'b0, 1'b0);
    edge_step();
    chk("R5 commit on 12th edge", 10'h3FF, 1'b0, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule